// File: doc/BRIEF.md
# I2C Byte Master Controller

This block is a single-master I2C engine. A host gives it one command at a time: generate a START, generate a STOP, send a byte, or receive a byte and then answer with ACK or NAK. The block sequences every bus bit as four equal quarter phases. Each quarter lasts a programmable number of system clocks, so the SCL period is four times (divider + 1) system clocks. The bus lines are open-drain. The block drives them only as pull-low enables and reads SDA back through a plain input.

For each command the block raises busy and moves the lines through the quarter phases of that command. When the command finishes it drops busy and pulses done. The data bits travel MSB first. After a transmitted byte the block samples the target's acknowledge and holds the result in an error flag. After a received byte the block presents the eight sampled bits. Between commands both lines keep the levels the last command left on them, so a START can follow a byte directly as a repeated start.

Top module: `i2cm_master`

## Requirements
- R1: After reset both pull-low enables are 0 (lines released), busy, done, the ACK-error flag and the received byte are all 0.
- R2: A command is accepted when cmd_valid_i is 1, busy is 0 and cmd_i holds a legal code: 1 = START, 2 = STOP, 3 = write byte, 4 = read byte then ACK, 5 = read byte then NAK. Busy is 1 from the cycle after the accepting edge. Codes 0, 6 and 7 are ignored, and so is any command offered while busy.
- R3: Each quarter phase lasts div+1 clocks. START and STOP take 4 quarters. Byte commands take 36 quarters (9 bits of 4 quarters).
- R4: START drives (scl_oe, sda_oe) per quarter as (1,0), (0,0), (0,1), (1,1), so SDA falls while SCL is high.
- R5: STOP drives (scl_oe, sda_oe) per quarter as (1,1), (0,1), (0,0), (0,0), so SDA rises while SCL is high and both lines end released.
- R6: In a byte command every bit holds SCL low in quarters 0 and 3 and releases it in quarters 1 and 2. SDA changes only at the start of quarter 0 and holds for the whole bit.
- R7: A write sends wdata MSB first with sda_oe equal to the inverse of the bit. In the ninth bit the block releases SDA and samples sda_i on the last clock of quarter 2. ack_err takes the sampled level, so 1 means no acknowledge. Each write overwrites it.
- R8: A read releases SDA for 8 bits and shifts sda_i in MSB first, sampled on the last clock of quarter 2. The ninth bit pulls SDA low for code 4 and leaves it released for code 5. rdata shows the byte once done pulses. Reads leave ack_err unchanged.
- R9: done is a one-cycle pulse in the first cycle with busy low after a command. The line enables then hold their final quarter values until the next command.
- R10: div_i is captured when a command is accepted. A change during a command does not alter that command's timing and applies from the next command on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_i | input | DIV_W | Quarter-phase length minus one, in clocks |
| cmd_valid_i | input | 1 | Command offer strobe |
| cmd_i | input | 3 | Command code |
| wdata_i | input | DATA_W | Byte to transmit on a write |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rdata_o | output | DATA_W | Last received byte |
| ack_err_o | output | 1 | Last write saw no acknowledge |

## Verification
A wrong quarter count or a divider that slipped shows up at once. The line enables land in the wrong quarter at the first quarter boundary, and busy falls early or late at the end of the command. A bit counter or shift register that went astray appears within one bit time as a wrong SDA enable while SCL is low, and it corrupts rdata or ack_err at done. Ignored commands are tested by offering them while idle and while busy, then comparing the waveform and the busy timing against an undisturbed command.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_STOP   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_RD_ACK = 3'd4,
        OP_RD_NAK = 3'd5
    } op_e;

    localparam int unsigned QTR_PER_BIT = 4;
endpackage

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             last_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.div = div_i;
            t_d.cnt = '0;
        end else if (run_i) begin
            t_d.cnt = (t_q.cnt == t_q.div) ? '0 : t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign last_o = run_i && (t_q.cnt == t_q.div);

    // R3: the count within a quarter never passes the captured length
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (t_q.cnt <= t_q.div));
endmodule

// File: rtl/i2cm_wave.sv
module i2cm_wave
    import i2cm_pkg::*;
(
    input  op_e        op_i,
    input  logic [1:0] qtr_i,
    input  logic       ack_bit_i,
    input  logic       tx_bit_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);
    logic scl_edge_low;
    assign scl_edge_low = (qtr_i == 2'd0) || (qtr_i == 2'd3);

    always_comb begin
        scl_oe_o = 1'b0;
        sda_oe_o = 1'b0;
        unique case (op_i)
            OP_START: begin
                scl_oe_o = scl_edge_low;
                sda_oe_o = qtr_i[1];
            end
            OP_STOP: begin
                scl_oe_o = (qtr_i == 2'd0);
                sda_oe_o = !qtr_i[1];
            end
            OP_WRITE: begin
                scl_oe_o = scl_edge_low;
                sda_oe_o = ack_bit_i ? 1'b0 : !tx_bit_i;
            end
            OP_RD_ACK: begin
                scl_oe_o = scl_edge_low;
                sda_oe_o = ack_bit_i;
            end
            OP_RD_NAK: begin
                scl_oe_o = scl_edge_low;
                sda_oe_o = 1'b0;
            end
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_err_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(DATA_W);
    localparam logic [1:0] QTR_SAMPLE = 2'(QTR_PER_BIT - 2);
    localparam logic [1:0] QTR_LAST   = 2'(QTR_PER_BIT - 1);

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [1:0]        qtr;
        logic [BIT_W-1:0]  bit_idx;
        logic [DATA_W-1:0] sh;
        logic              hold_scl;
        logic              hold_sda;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              ack_err;
    } ctl_t;

    ctl_t s_d, s_q;

    logic legal, accept, q_last, is_byte, is_read, at_ack;
    logic w_scl, w_sda;

    assign legal   = (cmd_i >= 3'd1) && (cmd_i <= 3'd5);
    assign accept  = cmd_valid_i && !s_q.busy && legal;
    assign is_read = (s_q.op == OP_RD_ACK) || (s_q.op == OP_RD_NAK);
    assign is_byte = is_read || (s_q.op == OP_WRITE);
    assign at_ack  = (s_q.bit_idx == ACK_IDX);

    i2cm_qtimer #(.DIV_W(DIV_W)) u_qtimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .run_i   (s_q.busy),
        .div_i   (div_i),
        .last_o  (q_last)
    );

    i2cm_wave u_wave (
        .op_i      (s_q.op),
        .qtr_i     (s_q.qtr),
        .ack_bit_i (at_ack),
        .tx_bit_i  (s_q.sh[DATA_W-1]),
        .scl_oe_o  (w_scl),
        .sda_oe_o  (w_sda)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.busy    = 1'b1;
            s_d.op      = op_e'(cmd_i);
            s_d.qtr     = '0;
            s_d.bit_idx = '0;
            s_d.sh      = wdata_i;
        end else if (s_q.busy && q_last) begin
            if (is_byte && (s_q.qtr == QTR_SAMPLE)) begin
                if (!at_ack && is_read)
                    s_d.sh = {s_q.sh[DATA_W-2:0], sda_i};
                if (at_ack && (s_q.op == OP_WRITE))
                    s_d.ack_err = sda_i;
            end
            if (s_q.qtr == QTR_LAST) begin
                if (!is_byte || at_ack) begin
                    s_d.busy     = 1'b0;
                    s_d.done     = 1'b1;
                    s_d.hold_scl = w_scl;
                    s_d.hold_sda = w_sda;
                    if (is_read) s_d.rdata = s_q.sh;
                end else begin
                    s_d.bit_idx = s_q.bit_idx + 1'b1;
                    if (s_q.op == OP_WRITE)
                        s_d.sh = {s_q.sh[DATA_W-2:0], 1'b0};
                end
            end
            s_d.qtr = s_q.qtr + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.op <= OP_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_oe_o  = s_q.busy ? w_scl : s_q.hold_scl;
    assign sda_oe_o  = s_q.busy ? w_sda : s_q.hold_sda;
    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;
    assign rdata_o   = s_q.rdata;
    assign ack_err_o = s_q.ack_err;

    // R9: done lasts exactly one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy only falls together with a done pulse
    a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R2: a running command is not cut short before its quarter ends
    a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !q_last) |=> busy_o);

    // R6: within a byte, SDA holds while SCL stays released
    a_r6_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && is_byte && !scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));

    // R4: the START falling edge of SDA happens with SCL released
    a_r4_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (s_q.op == OP_START) && $rose(sda_oe_o)) |-> !scl_oe_o);

    // R5: the STOP rising edge of SDA happens with SCL released
    a_r5_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (s_q.op == OP_STOP) && $fell(sda_oe_o)) |-> !scl_oe_o);
endmodule

// File: tb/i2cm_master_tb.sv
module i2cm_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic [7:0] wdata_i = 8'd0;
    logic       sda_i;
    logic       scl_oe_o, sda_oe_o, busy_o, done_o, ack_err_o;
    logic [7:0] rdata_o;
    logic       tgt_pull = 1'b0;
    logic       finished = 1'b0;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_i = !(sda_oe_o || tgt_pull);

    i2cm_master u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_i       (div_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .wdata_i     (wdata_i),
        .sda_i       (sda_i),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o),
        .ack_err_o   (ack_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected {scl_oe, sda_oe} for a quarter of a command
    function automatic logic [1:0] expw(input logic [2:0] c, input int b, input int q,
                                        input logic [7:0] wd);
        logic scl, sda;
        if (c == 3'd1) begin                 // R4
            scl = (q == 0) || (q == 3);
            sda = (q >= 2);
        end else if (c == 3'd2) begin        // R5
            scl = (q == 0);
            sda = (q <= 1);
        end else begin                       // R6 / R7 / R8
            scl = (q == 0) || (q == 3);
            if (b < 8) sda = (c == 3'd3) ? !wd[7-b] : 1'b0;
            else       sda = (c == 3'd4);
        end
        return {scl, sda};
    endfunction

    // issue one command and check every quarter, busy, done and results
    task automatic run_cmd(input logic [2:0] c, input logic [7:0] wd, input logic [7:0] tgt_byte,
                           input logic tgt_ack, input int d, input logic poke,
                           input logic [7:0] new_div, input logic exp_err);
        int nq;
        logic [1:0] last_w;
        nq = (c == 3'd1 || c == 3'd2) ? 4 : 36;
        cmd_valid_i = 1'b1;
        cmd_i       = c;
        wdata_i     = wd;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        last_w = 2'b00;
        for (int k = 0; k < nq; k++) begin
            int b, q;
            b = k / 4;
            q = k % 4;
            if (q == 0) begin
                if (c == 3'd3)      tgt_pull = (b == 8) ? tgt_ack : 1'b0;
                else if (c >= 3'd4) tgt_pull = (b < 8) ? !tgt_byte[7-b] : 1'b0;
                else                tgt_pull = 1'b0;
            end
            last_w = expw(c, b, q, wd);
            chk($sformatf("R3/R4/R5/R6 wave cmd%0d bit%0d q%0d", c, b, q),
                {30'd0, scl_oe_o, sda_oe_o}, {30'd0, last_w});
            chk("R2 busy during command", {31'd0, busy_o}, 32'd1);
            if (poke && k == 5) begin
                cmd_valid_i = 1'b1;   // R2: offered while busy, must be ignored
                cmd_i       = 3'd2;
                div_i       = new_div; // R10: must not affect this command
            end
            for (int j = 0; j < d; j++) begin
                @(negedge clk);
                cmd_valid_i = 1'b0;
            end
        end
        tgt_pull = 1'b0;
        chk("R9 busy low at end", {31'd0, busy_o}, 32'd0);
        chk("R9 done pulse", {31'd0, done_o}, 32'd1);
        chk("R9 lines hold final level", {30'd0, scl_oe_o, sda_oe_o}, {30'd0, last_w});
        if (c >= 3'd4) chk("R8 received byte", {24'd0, rdata_o}, {24'd0, tgt_byte});
        if (c >= 3'd3) chk("R7/R8 ack_err", {31'd0, ack_err_o}, {31'd0, exp_err});
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done_o}, 32'd0);
        chk("R9 lines still held", {30'd0, scl_oe_o, sda_oe_o}, {30'd0, last_w});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl released", {31'd0, scl_oe_o}, 32'd0);
        chk("R1 sda released", {31'd0, sda_oe_o}, 32'd0);
        chk("R1 busy", {31'd0, busy_o}, 32'd0);
        chk("R1 done", {31'd0, done_o}, 32'd0);
        chk("R1 ack_err", {31'd0, ack_err_o}, 32'd0);
        chk("R1 rdata", {24'd0, rdata_o}, 32'd0);
    endtask

    task automatic t_illegal_codes();
        for (int v = 0; v < 3; v++) begin
            cmd_valid_i = 1'b1;
            cmd_i = (v == 0) ? 3'd0 : 3'(v + 5);
            @(negedge clk);
            cmd_valid_i = 1'b0;
            @(negedge clk);
            chk("R2 illegal code ignored busy", {31'd0, busy_o}, 32'd0);
            chk("R2 illegal code ignored lines", {30'd0, scl_oe_o, sda_oe_o}, 32'd0);
            chk("R2 illegal code no done", {31'd0, done_o}, 32'd0);
        end
    endtask

    task automatic t_write_sequence();
        div_i = 8'd2;
        run_cmd(3'd1, 8'h00, 8'h00, 1'b0, 3, 1'b0, 8'd0, 1'b0);      // R4
        run_cmd(3'd3, 8'hA6, 8'h00, 1'b1, 3, 1'b0, 8'd0, 1'b0);      // R7 acked
        run_cmd(3'd3, 8'h3C, 8'h00, 1'b0, 3, 1'b0, 8'd0, 1'b1);      // R7 no ack
        run_cmd(3'd3, 8'h81, 8'h00, 1'b1, 3, 1'b1, 8'd0, 1'b0);      // R10, R2 busy poke
    endtask

    task automatic t_read_sequence();
        run_cmd(3'd1, 8'h00, 8'h00, 1'b0, 1, 1'b0, 8'd0, 1'b0);      // R10 new div, repeated start
        run_cmd(3'd4, 8'hFF, 8'h5A, 1'b0, 1, 1'b0, 8'd0, 1'b0);      // R8 with ACK
        run_cmd(3'd5, 8'h00, 8'hC3, 1'b0, 1, 1'b0, 8'd0, 1'b0);      // R8 with NAK
        run_cmd(3'd2, 8'h00, 8'h00, 1'b0, 1, 1'b0, 8'd0, 1'b0);      // R5
    endtask

    task automatic t_slow_divider();
        div_i = 8'd5;
        run_cmd(3'd1, 8'h00, 8'h00, 1'b0, 6, 1'b0, 8'd0, 1'b0);      // R3
        run_cmd(3'd3, 8'hFF, 8'h00, 1'b0, 6, 1'b0, 8'd0, 1'b1);      // R7
        run_cmd(3'd2, 8'h00, 8'h00, 1'b0, 6, 1'b0, 8'd0, 1'b0);      // R5
    endtask

    initial begin
        t_reset();
        t_write_sequence();
        t_read_sequence();
        t_illegal_codes();
        t_slow_divider();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule